// File: doc/BRIEF.md
# Ethernet Transmit Buffer Engine

This block sends one Ethernet frame that software has already placed in a packet buffer RAM inside the block. Software writes two pointers. The start pointer marks the per-packet control byte, which is never sent. The end pointer marks the final payload byte. Software then raises the transmit request. The engine reads the bytes that follow the control byte, up to and including the byte at the end pointer, and presents them on a byte stream with valid, ready and last.

When the frame completes, or is cancelled, the engine writes a seven-byte status record into the buffer starting just after the end pointer. It then drops the request bit and raises a transmit interrupt flag.

The buffer's only memory port is shared with an external DMA engine, under two waiting rules. A transmit request made while the DMA holds the port waits for the DMA to release it. A DMA request made while a transmission is pending is not granted until the request bit clears. Software fills the buffer and reads status records back through the DMA side of the port.

Top module: `etxb_top`

## Requirements
- R1: After reset, tx_busy, txif, tx_abort, irq, m_valid and dma_gnt are 0, and both pointers read 0.
- R2: A frame streams the bytes at addresses start+1 through end inclusive, with addresses wrapping modulo 2^AW, so its length is (end-start) mod 2^AW. m_last is 1 only on the byte read from the end address. m_valid and m_data hold steady while m_ready is low.
- R3: When end equals start, no byte is streamed, and the status record reports a count of 0 with the OK bit set.
- R4: The status record takes 7 bytes at end+1 through end+7, wrapping. Byte 0 holds the count of accepted bytes bits 7:0, and byte 1 holds bits 15:8. Byte 2 bit 0 means completed and bit 1 means aborted. Bytes 3 to 6 are 0.
- R5: At the end of a transmission, tx_busy falls, txif rises in the same cycle, and tx_abort shows whether the frame was aborted. Both pointers keep their programmed values.
- R6: A tx_cancel pulse while tx_busy is 1 aborts the frame. The status record then carries the number of bytes accepted so far. A cancel that arrives while waiting on the DMA takes effect once the DMA releases the port.
- R7: A tx_go that arrives while dma_gnt is 1 sets tx_busy, but m_valid stays 0 until dma_gnt has fallen.
- R8: While tx_busy is 1, a dma_req is not granted. dma_gnt rises in the cycle after tx_busy falls.
- R9: Once granted, dma_gnt stays 1 for as long as dma_req is 1. The engine never uses the memory port while dma_gnt is 1. A DMA read returns its data one cycle after the address.
- R10: While tx_busy is 1, pointer writes and further tx_go pulses have no effect.
- R11: irq equals txif AND ie_tx AND ie_glob. txif_clr clears txif, and a completion in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr_st | input | 1 | Write ptr_wdata to start pointer |
| ptr_wr_nd | input | 1 | Write ptr_wdata to end pointer |
| ptr_wdata | input | AW | Pointer write value |
| tx_go | input | 1 | Pulse: set transmit request |
| tx_cancel | input | 1 | Pulse: clear request, abort frame |
| txif_clr | input | 1 | Pulse: clear transmit interrupt flag |
| ie_tx | input | 1 | Transmit interrupt enable |
| ie_glob | input | 1 | Global Ethernet interrupt enable |
| dma_req | input | 1 | DMA wants the memory port (level) |
| dma_addr | input | AW | DMA memory address |
| dma_we | input | 1 | DMA write enable |
| dma_wdata | input | 8 | DMA write data |
| dma_rdata | output | 8 | DMA read data, one cycle after address |
| dma_gnt | output | 1 | DMA owns the memory port |
| m_data | output | 8 | Frame byte |
| m_valid | output | 1 | Frame byte valid |
| m_last | output | 1 | Byte is the last of the frame |
| m_ready | input | 1 | Sink accepts byte |
| st_ptr | output | AW | Start pointer readback |
| nd_ptr | output | AW | End pointer readback |
| tx_busy | output | 1 | Transmit request bit |
| txif | output | 1 | Transmit interrupt flag |
| tx_abort | output | 1 | Last frame was aborted |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with AW=6, a 64-byte buffer. With that size, start pointers spread over the whole buffer, together with lengths 0 to 12, produce frames and status records that cross the wrap point. That covers the modulo pointer arithmetic and the end+1 status placement for every kind of position. The small buffer also lets a single DMA pass refill the whole RAM before each frame, so each streamed byte and each status byte is compared against a value computed from its address. Directed cases then cover the two waiting rules, cancellation in the waiting state and in the middle of a frame, pointer writes while busy, and all four interrupt enable combinations.

// File: rtl/etxb_pkg.sv
package etxb_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_ISSUE,
        S_SHOW,
        S_STAT
    } seq_st_e;

    localparam int STAT_BYTES = 7;
    localparam int CNT_W      = 16;
endpackage

// File: rtl/etxb_ram.sv
module etxb_ram #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/etxb_arb.sv
module etxb_arb #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dma_req,
    input  logic          tx_busy,
    input  logic          eng_req,
    input  logic          eng_en,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_addr,
    input  logic [7:0]    eng_wdata,
    input  logic [AW-1:0] dma_addr,
    input  logic          dma_we,
    input  logic [7:0]    dma_wdata,
    output logic          dma_gnt,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_wdata
);
    logic gnt_d, gnt_q;

    always_comb begin
        gnt_d = gnt_q ? dma_req : (dma_req && !tx_busy);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gnt_q <= 1'b0;
        else        gnt_q <= gnt_d;
    end

    assign dma_gnt   = gnt_q;
    assign ram_en    = gnt_q ? 1'b1      : eng_en;
    assign ram_we    = gnt_q ? dma_we    : eng_we;
    assign ram_addr  = gnt_q ? dma_addr  : eng_addr;
    assign ram_wdata = gnt_q ? dma_wdata : eng_wdata;

    assert_port_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(gnt_q && eng_req));
    assert_gnt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q && dma_req) |=> gnt_q);
    assert_no_gnt_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !gnt_q) |=> !gnt_q);
endmodule

// File: rtl/etxb_seq.sv
module etxb_seq
    import etxb_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_wr_st,
    input  logic          ptr_wr_nd,
    input  logic [AW-1:0] ptr_wdata,
    input  logic          tx_go,
    input  logic          tx_cancel,
    input  logic          txif_clr,
    input  logic          dma_gnt,
    input  logic          m_ready,
    input  logic [7:0]    mem_rdata,
    output logic          mem_req,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic [7:0]    m_data,
    output logic          m_valid,
    output logic          m_last,
    output logic [AW-1:0] st_ptr,
    output logic [AW-1:0] nd_ptr,
    output logic          tx_busy,
    output logic          txif,
    output logic          tx_abort
);
    typedef struct packed {
        seq_st_e          state;
        logic [AW-1:0]    st;
        logic [AW-1:0]    nd;
        logic [AW-1:0]    rd;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       sidx;
        logic             busy;
        logic             txif;
        logic             abrt;
        logic             fail;
    } regs_t;

    regs_t r_d, r_q;
    logic  cancel;

    always_comb begin
        r_d       = r_q;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.rd;
        mem_wdata = 8'h00;
        cancel    = tx_cancel && r_q.busy;

        if (!r_q.busy) begin
            if (ptr_wr_st) r_d.st = ptr_wdata;
            if (ptr_wr_nd) r_d.nd = ptr_wdata;
        end
        if (txif_clr) r_d.txif = 1'b0;

        unique case (r_q.state)
            S_IDLE: begin
                if (tx_go) begin
                    r_d.busy  = 1'b1;
                    r_d.abrt  = 1'b0;
                    r_d.fail  = 1'b0;
                    r_d.cnt   = '0;
                    r_d.sidx  = '0;
                    r_d.state = S_WAIT;
                end
            end
            S_WAIT: begin
                if (cancel) r_d.fail = 1'b1;
                if (!dma_gnt) begin
                    if (cancel || r_q.fail) begin
                        r_d.state = S_STAT;
                    end else if (r_q.nd == r_q.st) begin
                        r_d.state = S_STAT;
                    end else begin
                        r_d.rd    = r_q.st + AW'(1);
                        r_d.state = S_ISSUE;
                    end
                end
            end
            S_ISSUE: begin
                mem_en = 1'b1;
                if (cancel) begin
                    r_d.fail  = 1'b1;
                    r_d.state = S_STAT;
                end else begin
                    r_d.state = S_SHOW;
                end
            end
            S_SHOW: begin
                if (m_ready) r_d.cnt = r_q.cnt + CNT_W'(1);
                if (cancel) begin
                    r_d.fail  = 1'b1;
                    r_d.state = S_STAT;
                end else if (m_ready) begin
                    if (r_q.rd == r_q.nd) begin
                        r_d.state = S_STAT;
                    end else begin
                        r_d.rd    = r_q.rd + AW'(1);
                        r_d.state = S_ISSUE;
                    end
                end
            end
            S_STAT: begin
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                mem_addr = r_q.nd + AW'(1) + AW'(r_q.sidx);
                case (r_q.sidx)
                    3'd0:    mem_wdata = r_q.cnt[7:0];
                    3'd1:    mem_wdata = r_q.cnt[15:8];
                    3'd2:    mem_wdata = {6'b0, r_q.fail, !r_q.fail};
                    default: mem_wdata = 8'h00;
                endcase
                r_d.sidx = r_q.sidx + 3'd1;
                if (r_q.sidx == 3'(STAT_BYTES - 1)) begin
                    r_d.busy  = 1'b0;
                    r_d.txif  = 1'b1;
                    r_d.abrt  = r_q.fail;
                    r_d.state = S_IDLE;
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: S_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req  = (r_q.state == S_ISSUE) || (r_q.state == S_SHOW) || (r_q.state == S_STAT);
    assign m_valid  = (r_q.state == S_SHOW);
    assign m_data   = mem_rdata;
    assign m_last   = (r_q.state == S_SHOW) && (r_q.rd == r_q.nd);
    assign st_ptr   = r_q.st;
    assign nd_ptr   = r_q.nd;
    assign tx_busy  = r_q.busy;
    assign txif     = r_q.txif;
    assign tx_abort = r_q.abrt;

    assert_beat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready && !tx_cancel) |=> (m_valid && $stable(m_data)));
    assert_ptr_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.busy |=> ($stable(r_q.st) && $stable(r_q.nd)));
    assert_flag_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.txif) |-> !r_q.busy);
    assert_no_stream_dma_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_gnt |-> !m_valid);
endmodule

// File: rtl/etxb_top.sv
module etxb_top #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_wr_st,
    input  logic          ptr_wr_nd,
    input  logic [AW-1:0] ptr_wdata,
    input  logic          tx_go,
    input  logic          tx_cancel,
    input  logic          txif_clr,
    input  logic          ie_tx,
    input  logic          ie_glob,
    input  logic          dma_req,
    input  logic [AW-1:0] dma_addr,
    input  logic          dma_we,
    input  logic [7:0]    dma_wdata,
    output logic [7:0]    dma_rdata,
    output logic          dma_gnt,
    output logic [7:0]    m_data,
    output logic          m_valid,
    output logic          m_last,
    input  logic          m_ready,
    output logic [AW-1:0] st_ptr,
    output logic [AW-1:0] nd_ptr,
    output logic          tx_busy,
    output logic          txif,
    output logic          tx_abort,
    output logic          irq
);
    logic          eng_req, eng_en, eng_we;
    logic [AW-1:0] eng_addr;
    logic [7:0]    eng_wdata;
    logic          ram_en, ram_we;
    logic [AW-1:0] ram_addr;
    logic [7:0]    ram_wdata, ram_rdata;

    etxb_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ptr_wr_st(ptr_wr_st), .ptr_wr_nd(ptr_wr_nd), .ptr_wdata(ptr_wdata),
        .tx_go(tx_go), .tx_cancel(tx_cancel), .txif_clr(txif_clr),
        .dma_gnt(dma_gnt), .m_ready(m_ready), .mem_rdata(ram_rdata),
        .mem_req(eng_req), .mem_en(eng_en), .mem_we(eng_we),
        .mem_addr(eng_addr), .mem_wdata(eng_wdata),
        .m_data(m_data), .m_valid(m_valid), .m_last(m_last),
        .st_ptr(st_ptr), .nd_ptr(nd_ptr),
        .tx_busy(tx_busy), .txif(txif), .tx_abort(tx_abort)
    );

    etxb_arb #(.AW(AW)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .dma_req(dma_req), .tx_busy(tx_busy),
        .eng_req(eng_req), .eng_en(eng_en), .eng_we(eng_we),
        .eng_addr(eng_addr), .eng_wdata(eng_wdata),
        .dma_addr(dma_addr), .dma_we(dma_we), .dma_wdata(dma_wdata),
        .dma_gnt(dma_gnt),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    etxb_ram #(.AW(AW)) u_ram (
        .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
        .wdata(ram_wdata), .rdata(ram_rdata)
    );

    assign dma_rdata = ram_rdata;
    assign irq       = txif & ie_tx & ie_glob;
endmodule

// File: tb/etxb_top_tb.sv
module etxb_top_tb;
    localparam int AW   = 6;
    localparam int SZ   = 1 << AW;
    localparam int MASK = SZ - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ptr_wr_st = 0, ptr_wr_nd = 0;
    logic [AW-1:0] ptr_wdata = '0;
    logic          tx_go = 0, tx_cancel = 0, txif_clr = 0, ie_tx = 0, ie_glob = 0;
    logic          dma_req = 0, dma_we = 0;
    logic [AW-1:0] dma_addr = '0;
    logic [7:0]    dma_wdata = '0;
    logic [7:0]    dma_rdata, m_data;
    logic          dma_gnt, m_valid, m_last, m_ready = 0;
    logic [AW-1:0] st_ptr, nd_ptr;
    logic          tx_busy, txif, tx_abort, irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    etxb_top #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ptr_wr_st(ptr_wr_st), .ptr_wr_nd(ptr_wr_nd),
        .ptr_wdata(ptr_wdata), .tx_go(tx_go), .tx_cancel(tx_cancel), .txif_clr(txif_clr),
        .ie_tx(ie_tx), .ie_glob(ie_glob), .dma_req(dma_req), .dma_addr(dma_addr),
        .dma_we(dma_we), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .dma_gnt(dma_gnt),
        .m_data(m_data), .m_valid(m_valid), .m_last(m_last), .m_ready(m_ready),
        .st_ptr(st_ptr), .nd_ptr(nd_ptr), .tx_busy(tx_busy), .txif(txif),
        .tx_abort(tx_abort), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int pat(input int a, input int seed);
        return (a * 7 + seed * 13 + 1) & 255;
    endfunction

    task automatic grab_port();
        int t = 0;
        dma_req = 1'b1;
        @(negedge clk);
        while (!dma_gnt && t < 5000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic free_port();
        dma_req = 1'b0;
        dma_we  = 1'b0;
        @(negedge clk);
    endtask

    task automatic fill(input int seed);
        grab_port();
        for (int a = 0; a < SZ; a++) begin
            dma_addr  = AW'(a);
            dma_wdata = 8'(pat(a, seed));
            dma_we    = 1'b1;
            @(negedge clk);
        end
        free_port();
    endtask

    task automatic set_ptrs(input int st, input int nd);
        ptr_wdata = AW'(st); ptr_wr_st = 1'b1;
        @(negedge clk);
        ptr_wr_st = 1'b0; ptr_wdata = AW'(nd); ptr_wr_nd = 1'b1;
        @(negedge clk);
        ptr_wr_nd = 1'b0;
    endtask

    task automatic pulse_go();
        tx_go = 1'b1;
        @(negedge clk);
        tx_go = 1'b0;
    endtask

    // Collect the stream until tx_busy drops; returns number of bytes accepted
    task automatic collect(input int st, input int len, input int seed, input int rmode,
                           output int got);
        int cyc = 0;
        got = 0;
        while (tx_busy && cyc < 5000) begin
            m_ready = (rmode == 0) ? 1'b1 : ((cyc % rmode) == 0);
            if (m_valid && m_ready) begin
                chk("R2 data", int'(m_data), pat((st + 1 + got) & MASK, seed));
                chk("R2 last", int'(m_last), (got == len - 1) ? 1 : 0);
                got++;
            end
            cyc++;
            @(negedge clk);
        end
        m_ready = 1'b0;
    endtask

    task automatic check_status(input int nd, input int cnt, input int b2);
        int v;
        grab_port();
        for (int k = 0; k < 7; k++) begin
            dma_addr = AW'((nd + 1 + k) & MASK);
            dma_we   = 1'b0;
            @(negedge clk);
            v = int'(dma_rdata);
            case (k)
                0:       chk("R4 status cnt lo", v, cnt & 255);
                1:       chk("R4 status cnt hi", v, (cnt >> 8) & 255);
                2:       chk("R4 status flags", v, b2);
                default: chk("R4 status zero", v, 0);
            endcase
        end
        free_port();
    endtask

    task automatic run_frame(input int st, input int len, input int seed, input int rmode);
        int nd = (st + len) & MASK;
        int got;
        fill(seed);
        set_ptrs(st, nd);
        pulse_go();
        collect(st, len, seed, rmode, got);
        if (len == 0) chk("R3 no bytes", got, 0);
        else          chk("R2 length", got, len);
        chk("R5 busy clear", int'(tx_busy), 0);
        chk("R5 txif set", int'(txif), 1);
        chk("R5 no abort", int'(tx_abort), 0);
        chk("R5 start kept", int'(st_ptr), st);
        chk("R5 end kept", int'(nd_ptr), nd);
        check_status(nd, len, 1);
        txif_clr = 1'b1;
        @(negedge clk);
        txif_clr = 1'b0;
        chk("R11 txif cleared", int'(txif), 0);
    endtask

    initial begin
        int got;
        int seed = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(tx_busy), 0);
        chk("R1 txif", int'(txif), 0);
        chk("R1 abort", int'(tx_abort), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 valid", int'(m_valid), 0);
        chk("R1 gnt", int'(dma_gnt), 0);
        chk("R1 st", int'(st_ptr), 0);
        chk("R1 nd", int'(nd_ptr), 0);

        // R2 R3 R4 R5 sweep over start positions, lengths and sink patterns
        for (int st = 0; st < SZ; st += 5) begin
            for (int len = 0; len <= 12; len++) begin
                run_frame(st, len, seed, seed % 3);
                seed++;
            end
        end

        // R6 cancel mid-frame after three bytes
        fill(3);
        set_ptrs(10, 30);
        pulse_go();
        got = 0;
        for (int c = 0; c < 200 && got < 3; c++) begin
            m_ready = 1'b1;
            if (m_valid) got++;
            @(negedge clk);
        end
        m_ready = 1'b0;
        repeat (2) @(negedge clk);
        tx_cancel = 1'b1;
        @(negedge clk);
        tx_cancel = 1'b0;
        for (int c = 0; c < 50 && tx_busy; c++) @(negedge clk);
        chk("R6 busy cleared", int'(tx_busy), 0);
        chk("R6 abort flag", int'(tx_abort), 1);
        chk("R6 txif", int'(txif), 1);
        check_status(30, 3, 2);

        // R7 tx waits for granted DMA; R6 cancel while waiting
        grab_port();
        set_ptrs(40, 44);
        pulse_go();
        chk("R7 busy set", int'(tx_busy), 1);
        for (int c = 0; c < 5; c++) begin
            chk("R7 no valid", int'(m_valid), 0);
            @(negedge clk);
        end
        tx_cancel = 1'b1;
        @(negedge clk);
        tx_cancel = 1'b0;
        chk("R6 still busy during DMA", int'(tx_busy), 1);
        free_port();
        for (int c = 0; c < 50 && tx_busy; c++) @(negedge clk);
        chk("R6 wait cancel abort", int'(tx_abort), 1);
        check_status(44, 0, 2);

        // R7 then full frame after DMA release
        fill(7);
        grab_port();
        set_ptrs(60, 3);
        pulse_go();
        for (int c = 0; c < 4; c++) begin
            chk("R7 stalled", int'(m_valid), 0);
            @(negedge clk);
        end
        free_port();
        collect(60, 7, 7, 0, got);
        chk("R7 frame after DMA", got, 7);
        chk("R7 ok", int'(tx_abort), 0);
        check_status(3, 7, 1);

        // R8 DMA blocked by busy; R10 writes ignored while busy
        fill(9);
        set_ptrs(0, 4);
        pulse_go();
        repeat (3) @(negedge clk);
        dma_req = 1'b1;
        ptr_wdata = AW'(33); ptr_wr_st = 1'b1; ptr_wr_nd = 1'b1; tx_go = 1'b1;
        @(negedge clk);
        ptr_wr_st = 1'b0; ptr_wr_nd = 1'b0; tx_go = 1'b0;
        chk("R10 start ignored", int'(st_ptr), 0);
        chk("R10 end ignored", int'(nd_ptr), 4);
        for (int c = 0; c < 5; c++) begin
            chk("R8 no grant", int'(dma_gnt), 0);
            @(negedge clk);
        end
        collect(0, 4, 9, 0, got);
        chk("R8 frame len", got, 4);
        chk("R8 grant not same cycle", int'(dma_gnt), 0);
        @(negedge clk);
        chk("R8 grant next cycle", int'(dma_gnt), 1);
        repeat (3) @(negedge clk);
        chk("R9 grant held", int'(dma_gnt), 1);
        chk("R10 no restart", int'(tx_busy), 0);
        dma_addr = AW'(1); dma_we = 1'b0;
        @(negedge clk);
        chk("R9 read latency", int'(dma_rdata), pat(1, 9));
        free_port();
        check_status(4, 4, 1);

        // R11 irq gating, txif set by previous frame
        for (int e = 0; e < 4; e++) begin
            ie_tx = e[0]; ie_glob = e[1];
            @(negedge clk);
            chk("R11 irq gate", int'(irq), (e == 3) ? 1 : 0);
        end
        txif_clr = 1'b1;
        @(negedge clk);
        txif_clr = 1'b0;
        chk("R11 clear", int'(txif), 0);
        chk("R11 irq low", int'(irq), 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule